// File: doc/BRIEF.md
# I2C Master FIFO Pacing Engine

This block sits between a host register port and the byte-level side of an I2C master. It buffers bytes in a small FIFO and tracks two residual-length counters: one for bytes still to cross the host side, one for bytes still to cross the bus side. A command loads both counters with its length and latches the transfer direction. The host then pushes bytes toward the bus sequencer during a write, or pops bytes the sequencer delivered during a read.

The engine raises a data-request flag that tells the host when to service the FIFO. In read direction the flag follows a high watermark. In write direction it follows a low watermark combined with the free space. When both counters reach zero the command completes, and if the command asked for a stop the transfer ends. Misuse by the host is reported through sticky error flags: pushing into a full FIFO, popping an empty one, using the FIFO in the wrong direction or while idle, or running past the host-side count. A single clear strobe empties the FIFO, zeroes the counters, drops busy and clears the errors.

Top module: `i2c_fifo_pacer`

## Requirements
- R1: After reset, fill, fe_cnt and be_cnt are 0, cmd_done is 1, and busy, data_req and all four error flags are 0.
- R2: A cmd_start pulse while cmd_done=1 loads fe_cnt and be_cnt with cmd_len, sets busy and latches cmd_read (1 = read) and cmd_stop. A cmd_start while cmd_done=0 sets err_invalid and leaves the counters unchanged.
- R3: The FIFO holds DEPTH (8) bytes and returns them in first-in first-out order. fill reports the current entry count. host_rdata is updated at the clock edge of an accepted pop.
- R4: Every accepted host push or pop decrements be_cnt. If be_cnt is already 0, the byte still moves, be_cnt stays 0 and err_access is set.
- R5: A host push into a full FIFO, or a pop from an empty FIFO, is dropped without changing fill or be_cnt. err_overrun is set only when pace_allow=0.
- R6: A host push during a read, a host pop during a write, or either one while busy=0, sets err_invalid and leaves fill unchanged.
- R7: In read direction, high_water is 1 when fill >= wm_high. data_req is 1 when (high_water and fill>0) or fe_cnt=0.
- R8: In write direction, low_water is 1 when fill <= wm_low. data_req is 1 when be_cnt>0 and ((DEPTH-fill) >= be_cnt or low_water).
- R9: Whenever both counters are 0, cmd_done=1 and data_req=0. If the command was issued with cmd_stop=1, busy falls one cycle later; otherwise busy stays 1.
- R10: In write direction, tx_valid is 1 when busy, the FIFO is non-empty and fe_cnt>0, and tx_data is the head byte. Each tx_valid&tx_ready cycle pops one byte and decrements fe_cnt. If tx_nack is 1 in that cycle, err_nack is set and busy falls.
- R11: In read direction, rx_ready is 1 when busy, the FIFO is not full and fe_cnt>0. Each rx_valid&rx_ready cycle pushes rx_data and decrements fe_cnt.
- R12: err_clear empties the FIFO, zeroes both counters, clears busy and clears all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Issue a command (one-cycle pulse) |
| cmd_read | input | 1 | Command direction, 1 = read |
| cmd_stop | input | 1 | End the bus transfer when the command completes |
| cmd_len | input | LEN_W | Command length in bytes |
| err_clear | input | 1 | Flush FIFO, counters, busy and errors |
| pace_allow | input | 1 | Suppress the overrun error on dropped host accesses |
| wm_high | input | WM_W | Read-direction high watermark |
| wm_low | input | WM_W | Write-direction low watermark |
| host_push | input | 1 | Host writes host_wdata into the FIFO |
| host_wdata | input | DW | Host write byte |
| host_pop | input | 1 | Host reads one byte from the FIFO |
| host_rdata | output | DW | Last byte popped by the host |
| tx_valid | output | 1 | Byte offered to the bus sequencer |
| tx_data | output | DW | Byte offered to the bus sequencer |
| tx_ready | input | 1 | Sequencer takes tx_data |
| tx_nack | input | 1 | Slave refused the byte taken this cycle |
| rx_valid | input | 1 | Sequencer delivers rx_data |
| rx_data | input | DW | Byte received from the bus |
| rx_ready | output | 1 | Engine can take a received byte |
| busy | output | 1 | Transfer active |
| cmd_done | output | 1 | Both residual counters are zero |
| data_req | output | 1 | Host should service the FIFO |
| high_water | output | 1 | Read fill at or above wm_high |
| low_water | output | 1 | Write fill at or below wm_low |
| fill | output | CW | FIFO entry count |
| fe_cnt | output | LEN_W | Bus-side residual count |
| be_cnt | output | LEN_W | Host-side residual count |
| err_invalid | output | 1 | Invalid access or command |
| err_overrun | output | 1 | Host access dropped without pacing |
| err_access | output | 1 | Host access past the host-side count |
| err_nack | output | 1 | Byte refused by the slave |

## Verification
Random write transfers use random lengths, low watermarks and bus-ready patterns. They separate the free-space branch of the write request rule from the low-water branch, and they check byte order across concurrent push and drain. Random read transfers use irregular delivery and host popping against random high watermarks. They show whether the request follows the watermark or the exhausted bus-side count. Directed cases reach a full FIFO and an empty FIFO with pacing on and off, a count overrun, wrong-direction and idle accesses, a mid-transfer NACK, a command issued during a transfer, and the clear strobe. Each of these flips exactly one error or state flag.

// File: rtl/i2c_fifo_pacer.sv
module i2c_fifo_pacer #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int LEN_W = 16,
  parameter int WM_W  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_read,
  input  logic             cmd_stop,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             err_clear,
  input  logic             pace_allow,
  input  logic [WM_W-1:0]  wm_high,
  input  logic [WM_W-1:0]  wm_low,
  input  logic             host_push,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_pop,
  output logic [DW-1:0]    host_rdata,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  input  logic             tx_nack,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             rx_ready,
  output logic             busy,
  output logic             cmd_done,
  output logic             data_req,
  output logic             high_water,
  output logic             low_water,
  output logic [CW-1:0]    fill,
  output logic [LEN_W-1:0] fe_cnt,
  output logic [LEN_W-1:0] be_cnt,
  output logic             err_invalid,
  output logic             err_overrun,
  output logic             err_access,
  output logic             err_nack
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rd_dir, stop_r;

  wire full    = (fill == CW'(DEPTH));
  wire empty   = (fill == '0);
  wire fe_zero = (fe_cnt == '0);
  wire be_zero = (be_cnt == '0);

  wire pop_req   = host_pop && !host_push;
  wire push_bad  = host_push && (!busy || rd_dir);
  wire pop_bad   = pop_req && (!busy || !rd_dir);
  wire push_ok   = host_push && busy && !rd_dir;
  wire pop_ok    = pop_req && busy && rd_dir;
  wire push_do   = push_ok && !full;
  wire pop_do    = pop_ok && !empty;
  wire host_drop = (push_ok && full) || (pop_ok && empty);
  wire host_do   = push_do || pop_do;

  assign cmd_done = fe_zero && be_zero;
  wire accept     = cmd_start && cmd_done;
  wire finish     = busy && stop_r && cmd_done;

  assign tx_valid = busy && !rd_dir && !empty && !fe_zero;
  assign tx_data  = mem[rp];
  assign rx_ready = busy && rd_dir && !full && !fe_zero;
  wire tx_fire    = tx_valid && tx_ready;
  wire rx_fire    = rx_valid && rx_ready;

  wire          wr_en   = push_do || rx_fire;
  wire          rd_en   = pop_do || tx_fire;
  wire [DW-1:0] wr_byte = rd_dir ? rx_data : host_wdata;

  assign high_water = busy && rd_dir && (32'(fill) >= 32'(wm_high));
  assign low_water  = busy && !rd_dir && (32'(fill) <= 32'(wm_low));

  wire rd_req = (high_water && !empty) || fe_zero;
  wire wr_req = !be_zero && ((32'(DEPTH) - 32'(fill) >= 32'(be_cnt)) || low_water);
  assign data_req = busy && !cmd_done && (rd_dir ? rd_req : wr_req);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
      fe_cnt <= '0; be_cnt <= '0;
      busy <= 1'b0; rd_dir <= 1'b0; stop_r <= 1'b0;
      err_invalid <= 1'b0; err_overrun <= 1'b0;
      err_access <= 1'b0; err_nack <= 1'b0;
      host_rdata <= '0;
    end else if (err_clear) begin
      wp <= '0; rp <= '0; fill <= '0;
      fe_cnt <= '0; be_cnt <= '0;
      busy <= 1'b0;
      err_invalid <= 1'b0; err_overrun <= 1'b0;
      err_access <= 1'b0; err_nack <= 1'b0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(wr_en) - CW'(rd_en);
      if (pop_do) host_rdata <= mem[rp];

      if (accept) begin
        fe_cnt <= cmd_len;
        be_cnt <= cmd_len;
        rd_dir <= cmd_read;
        stop_r <= cmd_stop;
      end else begin
        if (tx_fire || rx_fire) fe_cnt <= fe_cnt - 1'b1;
        if (host_do && !be_zero) be_cnt <= be_cnt - 1'b1;
      end

      if (host_do && be_zero) err_access <= 1'b1;
      if (host_drop && !pace_allow) err_overrun <= 1'b1;
      if (push_bad || pop_bad || (cmd_start && !cmd_done)) err_invalid <= 1'b1;
      if (tx_fire && tx_nack) err_nack <= 1'b1;

      if (accept) busy <= 1'b1;
      else if (tx_fire && tx_nack) busy <= 1'b0;
      else if (finish) busy <= 1'b0;
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= 32'(DEPTH)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !data_req); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cmd_start && !err_clear) |=> !busy); // R9
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !err_clear) |=> (fe_cnt + 1'b1 == $past(fe_cnt))); // R10
  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_nack && !err_clear) |=> (!busy && err_nack)); // R10
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !err_clear) |=> (fe_cnt + 1'b1 == $past(fe_cnt))); // R11
  AST_BE_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
    (push_do && be_zero && !err_clear) |=> err_access); // R4

endmodule

// File: tb/i2c_fifo_pacer_test.sv
`timescale 1ns/1ps
module i2c_fifo_pacer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_read = 0, cmd_stop = 0, err_clear = 0, pace_allow = 1;
  logic [15:0] cmd_len = 0;
  logic [3:0] wm_high = 0, wm_low = 0;
  logic host_push = 0, host_pop = 0, tx_ready = 0, tx_nack = 0, rx_valid = 0;
  logic [7:0] host_wdata = 0, rx_data = 0;
  logic [7:0] host_rdata, tx_data;
  logic tx_valid, rx_ready, busy, cmd_done, data_req, high_water, low_water;
  logic [3:0] fill;
  logic [15:0] fe_cnt, be_cnt;
  logic err_invalid, err_overrun, err_access, err_nack;

  int checks = 0, fails = 0;
  logic [7:0] q [64];

  always #2.5 clk = ~clk;

  i2c_fifo_pacer uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic bit dreq_exp(bit rd, int f, int fe, int be, int wh, int wl);
    if (fe == 0 && be == 0) return 0;
    if (rd) return ((f >= wh) && f > 0) || fe == 0;
    return be > 0 && ((8 - f) >= be || f <= wl);
  endfunction

  task automatic issue(input int n, input bit rd, input bit stp);
    cmd_len = 16'(n); cmd_read = rd; cmd_stop = stp; cmd_start = 1;
    tick();
    cmd_start = 0;
  endtask

  task automatic clear();
    err_clear = 1; tick(); err_clear = 0;
  endtask

  task automatic run_write(input int n, input int wl, input bit stp);
    int f = 0, fe = n, be = n, qh = 0, qt = 0;
    wm_low = 4'(wl);
    issue(n, 0, stp);
    chk("R2 fe load", fe_cnt, n); chk("R2 be load", be_cnt, n); chk("R2 busy", busy, 1);
    for (int c = 0; c < 3000 && (fe > 0 || be > 0); c++) begin
      bit psh = (be > 0) && ($urandom % 2 == 1);
      bit rdy = ($urandom % 3 != 0);
      bit tx = (f > 0) && (fe > 0) && rdy;
      bit ok = psh && (f < 8);
      logic [7:0] d = 8'($urandom);
      chk("R10 tx_valid", tx_valid, (f > 0 && fe > 0));
      if (tx) chk("R10 tx_data", tx_data, q[qh]);
      host_push = psh; host_wdata = d; tx_ready = rdy;
      tick();
      if (ok) begin q[qt] = d; qt++; end
      if (tx) qh++;
      f = f + int'(ok) - int'(tx); fe -= int'(tx); be -= int'(ok);
      chk("R3 fill", fill, f); chk("R10 fe", fe_cnt, fe); chk("R4 be", be_cnt, be);
      chk("R8 data_req", data_req, dreq_exp(0, f, fe, be, 0, wl));
      chk("R8 low_water", low_water, (f <= wl));
    end
    host_push = 0; tx_ready = 0;
    chk("R9 cmd_done", cmd_done, 1); chk("R9 data_req", data_req, 0);
    tick();
    chk("R9 busy after done", busy, !stp);
  endtask

  task automatic run_read(input int n, input int wh, input bit stp);
    int f = 0, fe = n, be = n, qh = 0, qt = 0;
    wm_high = 4'(wh);
    issue(n, 1, stp);
    chk("R2 fe load", fe_cnt, n); chk("R2 busy", busy, 1);
    for (int c = 0; c < 3000 && (fe > 0 || be > 0); c++) begin
      bit vld = ($urandom % 3 != 0);
      bit pop = (f > 0) && (be > 0) && ($urandom % 2 == 1);
      bit rx = vld && (f < 8) && (fe > 0);
      logic [7:0] d = 8'($urandom);
      chk("R11 rx_ready", rx_ready, (f < 8 && fe > 0));
      rx_valid = vld; rx_data = d; host_pop = pop;
      tick();
      if (rx) begin q[qt] = d; qt++; end
      if (pop) begin chk("R3 host_rdata order", host_rdata, q[qh]); qh++; end
      f = f + int'(rx) - int'(pop); fe -= int'(rx); be -= int'(pop);
      chk("R3 fill", fill, f); chk("R11 fe", fe_cnt, fe); chk("R4 be", be_cnt, be);
      chk("R7 data_req", data_req, dreq_exp(1, f, fe, be, wh, 0));
      chk("R7 high_water", high_water, (f >= wh));
    end
    rx_valid = 0; host_pop = 0;
    chk("R9 cmd_done", cmd_done, 1); chk("R9 data_req", data_req, 0);
    tick();
    chk("R9 busy after done", busy, !stp);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst_n = 1; tick();
    chk("R1 fill", fill, 0); chk("R1 fe", fe_cnt, 0); chk("R1 be", be_cnt, 0);
    chk("R1 cmd_done", cmd_done, 1); chk("R1 busy", busy, 0); chk("R1 data_req", data_req, 0);
    chk("R1 errors", {err_invalid, err_overrun, err_access, err_nack}, 0);

    for (int i = 0; i < 6; i++) begin
      run_write(1 + int'($urandom % 30), int'($urandom % 9), ($urandom % 2 == 1));
      run_read(1 + int'($urandom % 30), int'($urandom % 9), ($urandom % 2 == 1));
    end
    run_write(5, 0, 1);
    chk("R5 no error under pacing", {err_invalid, err_overrun, err_access, err_nack}, 0);

    issue(4, 0, 1);
    issue(7, 0, 1);
    chk("R2 rejected cmd flag", err_invalid, 1); chk("R2 rejected cmd fe", fe_cnt, 4);
    host_wdata = 8'h5a; host_push = 1; tick(); host_push = 0;
    clear();
    chk("R12 fill", fill, 0); chk("R12 fe", fe_cnt, 0); chk("R12 busy", busy, 0);
    chk("R12 errors", {err_invalid, err_overrun, err_access, err_nack}, 0);

    host_push = 1; tick(); host_push = 0;
    chk("R6 idle push flag", err_invalid, 1); chk("R6 idle push fill", fill, 0);
    clear();
    issue(2, 0, 1);
    host_pop = 1; tick(); host_pop = 0;
    chk("R6 pop in write", err_invalid, 1); chk("R6 pop in write fill", fill, 0);
    clear();
    issue(2, 1, 1);
    host_push = 1; tick(); host_push = 0;
    chk("R6 push in read", err_invalid, 1); chk("R6 push in read fill", fill, 0);
    clear();

    pace_allow = 0;
    issue(1, 0, 1);
    host_push = 1; tick();
    chk("R4 last byte no error", err_access, 0); chk("R4 be zero", be_cnt, 0);
    tick();
    chk("R4 past count", err_access, 1); chk("R4 byte still moved", fill, 2);
    for (int i = 0; i < 6; i++) tick();
    chk("R3 full", fill, 8); chk("R5 no overrun yet", err_overrun, 0);
    tick(); host_push = 0;
    chk("R5 dropped push fill", fill, 8); chk("R5 overrun unpaced", err_overrun, 1);
    clear();

    pace_allow = 1; wm_low = 0;
    issue(10, 0, 1);
    host_push = 1;
    for (int i = 0; i < 9; i++) tick();
    host_push = 0;
    chk("R5 paced fill", fill, 8); chk("R5 paced be", be_cnt, 2);
    chk("R5 paced no overrun", err_overrun, 0); chk("R8 no room no req", data_req, 0);
    tx_ready = 1; tx_nack = 1; tick(); tx_ready = 0; tx_nack = 0;
    chk("R10 nack flag", err_nack, 1); chk("R10 nack busy", busy, 0); chk("R10 nack fe", fe_cnt, 9);
    clear();

    pace_allow = 0;
    issue(2, 1, 1);
    host_pop = 1; tick(); host_pop = 0;
    chk("R5 empty pop unpaced", err_overrun, 1); chk("R5 empty pop be", be_cnt, 2);
    clear();

    pace_allow = 1; wm_high = 3;
    issue(5, 1, 1);
    rx_valid = 1; rx_data = 8'h11; tick(); tick(); rx_valid = 0;
    chk("R7 below mark", data_req, 0); chk("R7 fill 2", fill, 2);
    rx_valid = 1; tick(); rx_valid = 0;
    chk("R7 at mark", data_req, 1); chk("R7 high_water", high_water, 1);
    clear();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule